// File: doc/BRIEF.md
# BCD Calendar Counter with Hundredths

This block keeps wall-clock time and calendar date, with every field stored as packed BCD: hundredths of a second, seconds, minutes, hours, day of month, month, two-digit year and a three-bit day of week. A step enable advances the hundredths field. A parameter sets how many step enables make up one hundredth, and it is 1 for a plain 100 Hz tick. Carries ripple through all fields in the same clock cycle, so every output always shows one consistent time. The century is a fixed constant output.

The hour byte holds its own format selector. When bit 7 is set the hour counts 00 to 23. When bit 7 is clear the hour counts 12, 01 to 11 and bit 5 marks the afternoon. The last day of each month follows the month number and a leap rule: a year is a leap year when its two-digit value is divisible by four, which suits a fixed century of 20.

A one-cycle load strobe writes every field at once and restarts the step divider. Surrounding logic uses this to set the time. All fields are outputs, for snapshot reads and for alarm comparison.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After a synchronous active-low reset the outputs read hundredths 00, seconds 00, minutes 00, hour 80h (24-hour format, hour 00), date 01, month 01, year 00 and weekday 0. The century output always reads 20h.
- R2: The hundredths field advances by one on every TICKS_PER_STEP-th clock cycle in which `step_en` is high. Cycles with `step_en` low change no field.
- R3: Hundredths count 00 to 99, and seconds and minutes count 00 to 59, in packed BCD (low digit in bits 3:0). Each field wraps to 00 and carries into the next field in the same cycle.
- R4: With hour bit 7 set (24-hour format), bits 5:0 count 00 to 23 in BCD and bit 6 reads 0. A wrap from 23 to 00 advances the date.
- R5: With hour bit 7 clear (12-hour format), bit 5 is the PM flag and bits 4:0 count 12, 01 to 11 in BCD. The step from 11 to 12 toggles PM, and only the step from 11 PM to 12 AM advances the date.
- R6: The date counts from 01 and wraps to 01 after its last day: 31 for months 01, 03, 05, 07, 08, 10 and 12, 30 for months 04, 06, 09 and 11, and 28 or 29 for month 02. A wrap advances the month.
- R7: February has 29 days when the BCD year is divisible by four, including year 00, and 28 days otherwise.
- R8: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00, and the century output does not change.
- R9: The weekday counts 0 to 6. It advances exactly when the date advances and wraps from 6 to 0.
- R10: While `load_en` is high, all fields take the load inputs at the next edge, even if `step_en` is also high. The step divider restarts, so the next hundredths step needs a full TICKS_PER_STEP enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Step enable, one per divider phase |
| load_en | input | 1 | Load all fields from the load inputs |
| ld_hund | input | 8 | Load value, hundredths (BCD) |
| ld_sec | input | 8 | Load value, seconds (BCD) |
| ld_min | input | 8 | Load value, minutes (BCD) |
| ld_hour | input | 8 | Load value, hour byte with format bit 7 and PM bit 5 |
| ld_date | input | 8 | Load value, day of month (BCD) |
| ld_month | input | 8 | Load value, month (BCD) |
| ld_year | input | 8 | Load value, year (BCD) |
| ld_wday | input | 3 | Load value, day of week 0 to 6 |
| hund_o | output | 8 | Hundredths (BCD) |
| sec_o | output | 8 | Seconds (BCD) |
| min_o | output | 8 | Minutes (BCD) |
| hour_o | output | 8 | Hour byte |
| date_o | output | 8 | Day of month (BCD) |
| month_o | output | 8 | Month (BCD) |
| year_o | output | 8 | Year (BCD) |
| wday_o | output | 3 | Day of week |
| century_o | output | 8 | Fixed century, 20h |

## Verification
Reaching a month or year boundary by counting steps from reset would take millions of cycles. The bench therefore loads a time one hundredth before the boundary (xx:59:59.99 on the last day) and then applies one divider's worth of steps, so a single step runs the carry through every field. The same approach reaches both 12-hour transitions and each leap-year case. The divider restart is checked by leaving the divider part-way through a phase, loading, and then confirming that one further step does nothing. A load in the same cycle as a step must also leave the loaded values untouched.

// File: rtl/cal_pkg.sv
// Package: cal_pkg
// Shared BCD types and helper functions for the calendar counter.
// Assumes every BCD byte it is given holds two legal digits (0-9).
package cal_pkg;

    localparam int BCD_W = 8;
    localparam int WDAY_W = 3;

    typedef logic [BCD_W-1:0] bcd8_t;

    // Next BCD value of a two-digit byte (99 wraps to 00).
    function automatic bcd8_t bcd_inc(input bcd8_t v);
        bcd8_t r;
        if (v[3:0] == 4'd9) begin
            r[3:0] = 4'd0;
            r[7:4] = (v[7:4] == 4'd9) ? 4'd0 : v[7:4] + 4'd1;
        end else begin
            r[3:0] = v[3:0] + 4'd1;
            r[7:4] = v[7:4];
        end
        return r;
    endfunction

    // A BCD year is a leap year when its value is divisible by four.
    function automatic logic bcd_is_leap(input bcd8_t y);
        logic r;
        if (y[4] == 1'b0)
            r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        else
            r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return r;
    endfunction

    // Last legal date of a BCD month.
    function automatic bcd8_t last_date(input bcd8_t m, input logic leap);
        bcd8_t r;
        case (m)
            8'h02:                      r = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

    // Upper limit of the time-of-day fields below the hour (hundredths, seconds, minutes).
    function automatic bcd8_t low_field_max(input int idx);
        return (idx == 0) ? 8'h99 : 8'h59;
    endfunction

endpackage

// File: rtl/cal_step_divider.sv
// Module: cal_step_divider
// Turns step enables into one hundredth pulse per TICKS_PER_STEP enables.
// Assumes: the restart input clears the phase so counting begins afresh.
// When TICKS_PER_STEP is 1 the enable passes straight through.
module cal_step_divider #(
    parameter int TICKS_PER_STEP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic restart,
    output logic hund_step
);

    localparam int CNT_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;

    generate
        if (TICKS_PER_STEP == 1) begin : g_direct
            assign hund_step = step_en && !restart;
        end else begin : g_count
            localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_STEP - 1);
            logic [CNT_W-1:0] phase_q;

            // Phase counter: restarts on load, advances per enable.
            always_ff @(posedge clk) begin
                if (!rst_n || restart)
                    phase_q <= '0;
                else if (step_en)
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
            end

            assign hund_step = step_en && !restart && (phase_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/cal_bcd_field.sv
// Module: cal_bcd_field
// One two-digit BCD field counting MIN_VAL..max_i, with load and carry out.
// Assumes: loaded values are legal BCD within range; max_i may change
// between cycles (used by the date field).
module cal_bcd_field #(
    parameter logic [7:0] MIN_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       load_i,
    input  logic [7:0] load_val_i,
    input  logic [7:0] max_i,
    output logic [7:0] value_o,
    output logic       wrap_o
);
    import cal_pkg::*;

    bcd8_t value_q;

    // Field register: load first, then count with wrap to the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value_q <= MIN_VAL;
        else if (load_i)
            value_q <= load_val_i;
        else if (en_i)
            value_q <= (value_q == max_i) ? MIN_VAL : bcd_inc(value_q);
    end

    assign value_o = value_q;
    assign wrap_o  = en_i && (value_q == max_i);

    a_r3_wrap_to_min: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && value_q == max_i) |=> (value_q == MIN_VAL));

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> $stable(value_q));

endmodule

// File: rtl/cal_hour_field.sv
// Module: cal_hour_field
// Hour register with a per-register format bit (bit 7: 1 = 24-hour).
// In 12-hour format bit 5 marks PM and bits 4:0 run 12,01..11.
// Assumes loaded hours are legal for the format they select.
module cal_hour_field (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       load_i,
    input  logic [7:0] load_val_i,
    output logic [7:0] hour_o,
    output logic       day_wrap_o
);
    import cal_pkg::*;

    bcd8_t hour_q;
    bcd8_t hour_next;
    logic  day_edge;
    bcd8_t inc24;
    bcd8_t inc12;
    logic  unused_ld_bit6;

    assign unused_ld_bit6 = load_val_i[6];
    assign inc24 = bcd_inc({2'b00, hour_q[5:0]});
    assign inc12 = bcd_inc({3'b000, hour_q[4:0]});

    // Next-hour decode for both formats; flags the midnight edge.
    always_comb begin
        hour_next = hour_q;
        day_edge  = 1'b0;
        if (hour_q[7]) begin
            if (hour_q[5:0] == 6'h23) begin
                hour_next = 8'h80;
                day_edge  = 1'b1;
            end else begin
                hour_next = {2'b10, inc24[5:0]};
            end
        end else begin
            if (hour_q[4:0] == 5'h12) begin
                hour_next = {2'b00, hour_q[5], 5'h01};
            end else if (hour_q[4:0] == 5'h11) begin
                hour_next = {2'b00, ~hour_q[5], 5'h12};
                day_edge  = hour_q[5];
            end else begin
                hour_next = {2'b00, hour_q[5], inc12[4:0]};
            end
        end
    end

    // Hour register: load (bit 6 forced clear) or advance on minute carry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hour_q <= 8'h80;
        else if (load_i)
            hour_q <= {load_val_i[7], 1'b0, load_val_i[5:0]};
        else if (en_i)
            hour_q <= hour_next;
    end

    assign hour_o     = hour_q;
    assign day_wrap_o = en_i && day_edge;

    a_r4_wrap_24h: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && hour_q[7] && hour_q[5:0] == 6'h23) |=> (hour_q == 8'h80));

    a_r5_pm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && !hour_q[7] && hour_q[4:0] == 5'h11)
            |=> (hour_q[5] != $past(hour_q[5]) && hour_q[4:0] == 5'h12));

    a_r4_bit6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hour_q[6] == 1'b0));

endmodule

// File: rtl/cal_weekday.sv
// Module: cal_weekday
// Day-of-week counter 0..6, advancing once per date advance.
// Assumes loaded values lie in 0..6.
module cal_weekday #(
    parameter int W = cal_pkg::WDAY_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] wday_o
);

    localparam logic [W-1:0] LAST_DAY = W'(6);

    logic [W-1:0] wday_q;

    // Weekday register: load or advance modulo seven.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wday_q <= '0;
        else if (load_i)
            wday_q <= load_val_i;
        else if (en_i)
            wday_q <= (wday_q == LAST_DAY) ? '0 : wday_q + 1'b1;
    end

    assign wday_o = wday_q;

    a_r9_wrap_week: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && wday_q == LAST_DAY) |=> (wday_q == '0));

endmodule

// File: rtl/bcd_calendar_counter.sv
// Module: bcd_calendar_counter
// Top of the BCD calendar: divider, hundredths/seconds/minutes chain,
// hour, date, month, year and weekday. All carries settle in one cycle.
// Assumes loaded values are legal BCD; the century is a fixed parameter.
module bcd_calendar_counter #(
    parameter int         TICKS_PER_STEP = 1,
    parameter logic [7:0] CENTURY        = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_en,
    input  logic       load_en,
    input  logic [7:0] ld_hund,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_date,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    input  logic [2:0] ld_wday,
    output logic [7:0] hund_o,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [2:0] wday_o,
    output logic [7:0] century_o
);
    import cal_pkg::*;

    localparam int N_LOW = 3;

    logic        hund_step;
    logic [N_LOW:0] low_en;
    bcd8_t       low_ld  [N_LOW];
    bcd8_t       low_val [N_LOW];
    logic        day_carry;
    logic        date_wrap;
    logic        month_wrap;
    logic        year_wrap_unused;
    bcd8_t       date_max;

    cal_step_divider #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .restart   (load_en),
        .hund_step (hund_step)
    );

    assign low_en[0] = hund_step;
    assign low_ld[0] = ld_hund;
    assign low_ld[1] = ld_sec;
    assign low_ld[2] = ld_min;

    generate
        for (genvar i = 0; i < N_LOW; i++) begin : g_low
            cal_bcd_field #(.MIN_VAL(8'h00)) u_field (
                .clk        (clk),
                .rst_n      (rst_n),
                .en_i       (low_en[i]),
                .load_i     (load_en),
                .load_val_i (low_ld[i]),
                .max_i      (low_field_max(i)),
                .value_o    (low_val[i]),
                .wrap_o     (low_en[i+1])
            );
        end
    endgenerate

    cal_hour_field u_hour (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (low_en[N_LOW]),
        .load_i     (load_en),
        .load_val_i (ld_hour),
        .hour_o     (hour_o),
        .day_wrap_o (day_carry)
    );

    assign date_max = last_date(month_o, bcd_is_leap(year_o));

    cal_bcd_field #(.MIN_VAL(8'h01)) u_date (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (day_carry),
        .load_i     (load_en),
        .load_val_i (ld_date),
        .max_i      (date_max),
        .value_o    (date_o),
        .wrap_o     (date_wrap)
    );

    cal_bcd_field #(.MIN_VAL(8'h01)) u_month (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (date_wrap),
        .load_i     (load_en),
        .load_val_i (ld_month),
        .max_i      (8'h12),
        .value_o    (month_o),
        .wrap_o     (month_wrap)
    );

    cal_bcd_field #(.MIN_VAL(8'h00)) u_year (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (month_wrap),
        .load_i     (load_en),
        .load_val_i (ld_year),
        .max_i      (8'h99),
        .value_o    (year_o),
        .wrap_o     (year_wrap_unused)
    );

    cal_weekday u_wday (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (day_carry),
        .load_i     (load_en),
        .load_val_i (ld_wday),
        .wday_o     (wday_o)
    );

    assign hund_o    = low_val[0];
    assign sec_o     = low_val[1];
    assign min_o     = low_val[2];
    assign century_o = CENTURY;

    a_r2_quiet_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> ($stable(hund_o) && $stable(date_o)));

    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (hund_o == $past(ld_hund) && sec_o == $past(ld_sec)
                     && year_o == $past(ld_year) && wday_o == $past(ld_wday)));

    a_r7_leap_feb29: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && day_carry && month_o == 8'h02 && date_o == 8'h28
         && year_o[4] == 1'b0 && year_o[3:0] == 4'd4) |=> (date_o == 8'h29));

    a_r9_weekday_follows_date: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !day_carry) |=> $stable(wday_o));

endmodule

// File: tb/bcd_calendar_counter_bench.sv
// Bench: scoreboard style. Driver tasks push expected snapshots into a
// queue; a monitor pops and compares them against the outputs.
module bcd_calendar_counter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       step_en;
    logic       load_en;
    logic [7:0] ld_hund, ld_sec, ld_min, ld_hour, ld_date, ld_month, ld_year;
    logic [2:0] ld_wday;
    logic [7:0] hund_o, sec_o, min_o, hour_o, date_o, month_o, year_o, century_o;
    logic [2:0] wday_o;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    typedef struct {
        int          req;
        logic [66:0] exp;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_calendar_counter #(.TICKS_PER_STEP(TPS), .CENTURY(8'h20)) u_bcd_calendar_counter (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .load_en(load_en),
        .ld_hund(ld_hund), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year), .ld_wday(ld_wday),
        .hund_o(hund_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o), .wday_o(wday_o),
        .century_o(century_o)
    );

    function automatic logic [66:0] pk(input logic [7:0] h, s, m, hr, d, mo, y,
                                       input logic [2:0] w);
        return {8'h20, h, s, m, hr, d, mo, y, w};
    endfunction

    // Driver side: queue one expected snapshot.
    task automatic expect_snap(input int req, input logic [66:0] e);
        sb_q.push_back('{req: req, exp: e});
    endtask

    // Called at a negedge: drive step_en for n sampled edges.
    task automatic steps(input int n);
        step_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        step_en = 1'b0;
    endtask

    task automatic set_ld(input logic [7:0] h, s, m, hr, d, mo, y, input logic [2:0] w);
        ld_hund = h; ld_sec = s; ld_min = m; ld_hour = hr;
        ld_date = d; ld_month = mo; ld_year = y; ld_wday = w;
    endtask

    // Called at a negedge: one-cycle load, optionally with a step in the same cycle.
    task automatic load_all(input logic [7:0] h, s, m, hr, d, mo, y, input logic [2:0] w,
                            input bit with_step);
        set_ld(h, s, m, hr, d, mo, y, w);
        load_en = 1'b1;
        step_en = with_step;
        @(posedge clk);
        @(negedge clk);
        load_en = 1'b0;
        step_en = 1'b0;
    endtask

    // Load one hundredth before the end of a day, then one full step.
    task automatic roll_day(input logic [7:0] hr, d, mo, y, input logic [2:0] w);
        load_all(8'h99, 8'h59, 8'h59, hr, d, mo, y, w, 1'b0);
        steps(TPS);
    endtask

    // Monitor: after each negedge, compare every queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [66:0] act;
                it  = sb_q.pop_front();
                act = {century_o, hund_o, sec_o, min_o, hour_o, date_o, month_o, year_o, wday_o};
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL R%0d: actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; step_en = 1'b0; load_en = 1'b0;
        set_ld(8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 3'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and fixed century
        expect_snap(1, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 3'd0));

        // R2: half a divider phase changes nothing, full phase steps once
        steps(1);
        expect_snap(2, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 3'd0));
        steps(1);
        expect_snap(2, pk(8'h01, 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 3'd0));
        repeat (5) @(negedge clk);
        expect_snap(2, pk(8'h01, 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 3'd0));
        // R3: BCD digit carry 09 -> 10
        steps(18);
        expect_snap(3, pk(8'h10, 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 3'd0));

        // R10: load restarts the divider phase
        steps(1);
        load_all(8'h99, 8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 3'd6, 1'b0);
        expect_snap(10, pk(8'h99, 8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 3'd6));
        steps(1);
        expect_snap(10, pk(8'h99, 8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 3'd6));
        // R3 R4 R6 R8 R9: full rollover, year 99 -> 00, century unchanged
        steps(1);
        expect_snap(8, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 3'd0));

        // R10: load wins over a same-cycle step
        steps(1);
        load_all(8'h05, 8'h30, 8'h20, 8'h94, 8'h09, 8'h03, 8'h50, 3'd4, 1'b1);
        expect_snap(10, pk(8'h05, 8'h30, 8'h20, 8'h94, 8'h09, 8'h03, 8'h50, 3'd4));
        steps(1);
        expect_snap(10, pk(8'h05, 8'h30, 8'h20, 8'h94, 8'h09, 8'h03, 8'h50, 3'd4));
        steps(1);
        expect_snap(2, pk(8'h06, 8'h30, 8'h20, 8'h94, 8'h09, 8'h03, 8'h50, 3'd4));

        // R4: bit 6 of a loaded hour reads back clear
        load_all(8'h00, 8'h00, 8'h00, 8'hC7, 8'h09, 8'h03, 8'h50, 3'd4, 1'b0);
        expect_snap(4, pk(8'h00, 8'h00, 8'h00, 8'h87, 8'h09, 8'h03, 8'h50, 3'd4));
        // R3 R4: minute carry into 24-hour hour 09 -> 10
        load_all(8'h99, 8'h59, 8'h59, 8'h89, 8'h09, 8'h03, 8'h50, 3'd4, 1'b0);
        steps(TPS);
        expect_snap(4, pk(8'h00, 8'h00, 8'h00, 8'h90, 8'h09, 8'h03, 8'h50, 3'd4));

        // R6 R9: date 09 -> 10 within a month
        roll_day(8'hA3, 8'h09, 8'h03, 8'h50, 3'd4);
        expect_snap(6, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h10, 8'h03, 8'h50, 3'd5));

        // R5: 11 AM -> 12 PM, no date change
        roll_day(8'h11, 8'h15, 8'h06, 8'h24, 3'd2);
        expect_snap(5, pk(8'h00, 8'h00, 8'h00, 8'h32, 8'h15, 8'h06, 8'h24, 3'd2));
        // R5: 11 PM -> 12 AM advances date and weekday
        roll_day(8'h31, 8'h15, 8'h06, 8'h24, 3'd2);
        expect_snap(5, pk(8'h00, 8'h00, 8'h00, 8'h12, 8'h16, 8'h06, 8'h24, 3'd3));
        // R5: 12 AM -> 01 AM
        roll_day(8'h12, 8'h15, 8'h06, 8'h24, 3'd2);
        expect_snap(5, pk(8'h00, 8'h00, 8'h00, 8'h01, 8'h15, 8'h06, 8'h24, 3'd2));
        // R5: 12 PM -> 01 PM
        roll_day(8'h32, 8'h15, 8'h06, 8'h24, 3'd2);
        expect_snap(5, pk(8'h00, 8'h00, 8'h00, 8'h21, 8'h15, 8'h06, 8'h24, 3'd2));

        // R7: leap years 24, 00, 12; common years 23, 10
        roll_day(8'hA3, 8'h28, 8'h02, 8'h24, 3'd1);
        expect_snap(7, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h29, 8'h02, 8'h24, 3'd2));
        roll_day(8'hA3, 8'h29, 8'h02, 8'h24, 3'd1);
        expect_snap(7, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h24, 3'd2));
        roll_day(8'hA3, 8'h28, 8'h02, 8'h23, 3'd1);
        expect_snap(7, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h23, 3'd2));
        roll_day(8'hA3, 8'h28, 8'h02, 8'h00, 3'd1);
        expect_snap(7, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h29, 8'h02, 8'h00, 3'd2));
        roll_day(8'hA3, 8'h28, 8'h02, 8'h10, 3'd1);
        expect_snap(7, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h03, 8'h10, 3'd2));
        roll_day(8'hA3, 8'h28, 8'h02, 8'h12, 3'd1);
        expect_snap(7, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h29, 8'h02, 8'h12, 3'd2));

        // R6: month lengths 30 and 31
        roll_day(8'hA3, 8'h30, 8'h04, 8'h33, 3'd3);
        expect_snap(6, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h05, 8'h33, 3'd4));
        roll_day(8'hA3, 8'h29, 8'h04, 8'h33, 3'd3);
        expect_snap(6, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h30, 8'h04, 8'h33, 3'd4));
        roll_day(8'hA3, 8'h31, 8'h07, 8'h33, 3'd3);
        expect_snap(6, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h08, 8'h33, 3'd4));
        roll_day(8'hA3, 8'h30, 8'h08, 8'h33, 3'd3);
        expect_snap(6, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h31, 8'h08, 8'h33, 3'd4));
        roll_day(8'hA3, 8'h30, 8'h11, 8'h33, 3'd6);
        expect_snap(6, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h12, 8'h33, 3'd0));

        // R8: year end 45 -> 46
        roll_day(8'hA3, 8'h31, 8'h12, 8'h45, 3'd5);
        expect_snap(8, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h46, 3'd6));

        // R2: no steps, nothing moves
        repeat (20) @(negedge clk);
        expect_snap(2, pk(8'h00, 8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h46, 3'd6));

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule